// File: doc/BRIEF.md
# Time-Stamp Counter with Adjust Register

This block gives each of several logical processors its own view of one free-running 64-bit base count. A processor reads its time stamp as the base count plus a private 64-bit offset. Beside the time stamp, each processor has an adjust register that records the net signed shift software has applied to its time stamp. The two registers are coupled. Writing the time stamp moves the adjust register by the same signed amount. Writing the adjust register moves the time stamp by the same signed amount. All arithmetic is modulo 2^64.

Software reaches both registers through a single-cycle request port. A request presents a processor index, a register address, a write flag and 64-bit write data. A small access state machine answers one cycle later. It enters `S_RD_REPLY` for a read of a known register and drives the value with `rd_valid`. It enters `S_WR_DONE` for an accepted write, which returns nothing. It enters `S_BAD` for an unknown address or processor index, which raises `err` for one cycle. With no request it returns to `S_IDLE`. The next state depends only on the request in the current cycle, so every state can move to every other state and requests can follow each other in back-to-back cycles.

Top module: `tsc_adjust_unit`

## Requirements
- R1: After reset, every processor's adjust register reads 0 and its offset is 0, so a time-stamp read returns the raw base count, which starts at 0 and grows by one per cycle.
- R2: A read of address 0x010 (time stamp) returns base count plus that processor's offset modulo 2^64, as sampled in the request cycle, with `rd_valid` high in the next cycle.
- R3: After a time-stamp write of V, a read issued k cycles later returns V+k; a read in the very next cycle returns V+1.
- R4: A time-stamp write changes the adjust register by (new offset − old offset), where the new offset is V minus the base count in the write cycle.
- R5: A write of A to address 0x03B (adjust) adds (A − old adjust) to the offset, so the time stamp shifts by the same signed amount.
- R6: A read of the adjust register returns the last value stored in it, unchanged.
- R7: A write to one processor leaves every other processor's time stamp and adjust register untouched.
- R8: A request to any other address, or to a processor index ≥ the processor count, raises `err` for exactly one cycle. A read of this kind returns 0 with `rd_valid` low, and a write of this kind changes no state.
- R9: Time stamp, offset and adjust arithmetic wrap modulo 2^64 with no saturation, so a negative delta is a wrapped subtraction.
- R10: A write request never raises `rd_valid`, and `rd_data` is 0 whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the base count advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| cpu | input | CPU_W (2) | Logical processor index |
| addr | input | ADDR_W (12) | Register address: 0x010 time stamp, 0x03B adjust |
| wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read reply valid, one cycle after the request |
| rd_data | output | 64 | Read reply data |
| err | output | 1 | One-cycle pulse for an unknown address or processor |

## Verification
A time-stamp write always coincides with the base count's own increment. The new offset must take the base value from before that edge, so the bench writes V and issues a read in the very next cycle. It expects exactly V+1, and V+k after idle gaps. The case is provoked again at the 64-bit wrap by writing all ones and expecting 0. The bench also confirms that the adjust register moved by the implied delta in that same write. It keeps its own base count and per-processor offset and adjust models, built from the formulas above.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int TSC_W = 64;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_ADJ
    } reg_sel_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_REPLY,
        S_WR_DONE,
        S_BAD
    } acc_state_t;

endpackage

// File: rtl/tsc_base_counter.sv
module tsc_base_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/tsc_decode.sv
module tsc_decode
    import tsc_pkg::*;
#(
    parameter int              NPROC    = 4,
    parameter int              CPU_W    = 2,
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] ADJ_ADDR = 12'h03B
) (
    input  logic [CPU_W-1:0]  cpu,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int CPU_SPAN = 1 << CPU_W;

    logic cpu_ok;

    generate
        if (NPROC >= CPU_SPAN) begin : g_full
            assign cpu_ok = 1'b1;
        end else begin : g_part
            assign cpu_ok = ({1'b0, cpu} < (CPU_W+1)'(NPROC));
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (cpu_ok) begin
            if (addr == CNT_ADDR) begin
                sel = SEL_CNT;
            end else if (addr == ADJ_ADDR) begin
                sel = SEL_ADJ;
            end
        end
    end

endmodule

// File: rtl/tsc_cpu_slot.sv
module tsc_cpu_slot #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cnt,
    input  logic         wr_adj,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] base,
    output logic [W-1:0] off_q,
    output logic [W-1:0] adj_q
);

    logic [W-1:0] off_from_cnt;
    logic [W-1:0] adj_delta;

    // Offset implied by a time-stamp write, using the pre-edge base count.
    assign off_from_cnt = wdata - base;
    // Signed (wrapped) change requested by an adjust write.
    assign adj_delta    = wdata - adj_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            adj_q <= '0;
        end else if (wr_cnt) begin
            adj_q <= adj_q + (off_from_cnt - off_q);
            off_q <= off_from_cnt;
        end else if (wr_adj) begin
            off_q <= off_q + adj_delta;
            adj_q <= wdata;
        end
    end

endmodule

// File: rtl/tsc_access_fsm.sv
module tsc_access_fsm
    import tsc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         wr,
    input  reg_sel_t     sel,
    input  logic [W-1:0] rd_value,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         err
);

    acc_state_t state_q;
    acc_state_t state_d;
    logic [W-1:0] data_q;

    always_comb begin
        state_d = S_IDLE;
        if (req) begin
            unique case (sel)
                SEL_NONE: state_d = S_BAD;
                SEL_CNT,
                SEL_ADJ:  state_d = wr ? S_WR_DONE : S_RD_REPLY;
                default:  state_d = S_BAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state_d == S_RD_REPLY) begin
            data_q <= rd_value;
        end else begin
            data_q <= '0;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_RD_REPLY: rd_valid = 1'b1;
            S_WR_DONE:  ;
            S_BAD:      err = 1'b1;
            default:    ;
        endcase
        rd_data = data_q;
    end

endmodule

// File: rtl/tsc_adjust_unit.sv
module tsc_adjust_unit
    import tsc_pkg::*;
#(
    parameter int                NPROC    = 4,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] ADJ_ADDR = 12'h03B,
    localparam int               CPU_W    = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int               W        = TSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [CPU_W-1:0]  cpu,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic              rd_valid,
    output logic [W-1:0]      rd_data,
    output logic              err
);

    reg_sel_t     sel;
    logic [W-1:0] base;
    logic [W-1:0] off_q [NPROC];
    logic [W-1:0] adj_q [NPROC];
    logic [NPROC*W-1:0] off_flat;
    logic [NPROC*W-1:0] adj_flat;
    logic [W-1:0] pick_off;
    logic [W-1:0] pick_adj;
    logic [W-1:0] rd_value;

    tsc_base_counter #(.W(W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .count (base)
    );

    tsc_decode #(
        .NPROC    (NPROC),
        .CPU_W    (CPU_W),
        .ADDR_W   (ADDR_W),
        .CNT_ADDR (CNT_ADDR),
        .ADJ_ADDR (ADJ_ADDR)
    ) u_decode (
        .cpu  (cpu),
        .addr (addr),
        .sel  (sel)
    );

    generate
        for (genvar i = 0; i < NPROC; i++) begin : g_slot
            logic hit;
            assign hit = req && wr && (cpu == CPU_W'(i));

            tsc_cpu_slot #(.W(W)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_cnt (hit && (sel == SEL_CNT)),
                .wr_adj (hit && (sel == SEL_ADJ)),
                .wdata  (wdata),
                .base   (base),
                .off_q  (off_q[i]),
                .adj_q  (adj_q[i])
            );

            assign off_flat[i*W +: W] = off_q[i];
            assign adj_flat[i*W +: W] = adj_q[i];
        end
    endgenerate

    always_comb begin
        pick_off = '0;
        pick_adj = '0;
        for (int i = 0; i < NPROC; i++) begin
            if (cpu == CPU_W'(i)) begin
                pick_off = off_flat[i*W +: W];
                pick_adj = adj_flat[i*W +: W];
            end
        end
        rd_value = (sel == SEL_CNT) ? (base + pick_off) : pick_adj;
    end

    tsc_access_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .wr       (wr),
        .sel      (sel),
        .rd_value (rd_value),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .err      (err)
    );

endmodule

// File: rtl/tsc_adjust_unit_chk.sv
module tsc_adjust_unit_chk #(
    parameter int                NPROC    = 4,
    parameter int                ADDR_W   = 12,
    parameter int                CPU_W    = 2,
    parameter int                W        = 64,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] ADJ_ADDR = 12'h03B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              wr,
    input logic [CPU_W-1:0]  cpu,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic [W-1:0]      rd_data,
    input logic              err,
    input logic [W-1:0]      base,
    input logic [NPROC*W-1:0] off_flat,
    input logic [NPROC*W-1:0] adj_flat
);

    logic good;
    logic seen;

    assign good = ({1'b0, cpu} < (CPU_W+1)'(NPROC)) &&
                  ((addr == CNT_ADDR) || (addr == ADJ_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r2_read_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && good) |=> rd_valid);

    a_r8_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !good) |=> (err && !rd_valid));

    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (seen && $past(req && !good)));

    a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr) |=> !rd_valid);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    a_r3_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (base == $past(base) + W'(1)));

    generate
        for (genvar i = 0; i < NPROC; i++) begin : g_chk
            // R4 and R5 together keep adjust equal to offset, as both start at 0.
            a_r4_adj_tracks_offset: assert property (@(posedge clk) disable iff (!rst_n)
                adj_flat[i*W +: W] == off_flat[i*W +: W]);

            a_r7_slot_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                (req && wr && (cpu != CPU_W'(i))) |=>
                    ($stable(off_flat[i*W +: W]) && $stable(adj_flat[i*W +: W])));
        end
    endgenerate

endmodule

bind tsc_adjust_unit tsc_adjust_unit_chk #(
    .NPROC    (NPROC),
    .ADDR_W   (ADDR_W),
    .CPU_W    (CPU_W),
    .W        (W),
    .CNT_ADDR (CNT_ADDR),
    .ADJ_ADDR (ADJ_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr       (wr),
    .cpu      (cpu),
    .addr     (addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .err      (err),
    .base     (base),
    .off_flat (off_flat),
    .adj_flat (adj_flat)
);

// File: tb/test_tsc_adjust_unit.sv
module test_tsc_adjust_unit;

    localparam logic [11:0] A_CNT = 12'h010;
    localparam logic [11:0] A_ADJ = 12'h03B;

    typedef struct packed {
        logic        req;
        logic        wr;
        logic [1:0]  cpu;
        logic [11:0] addr;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 2'd0, A_CNT, 64'h0000_0000_0000_1000}, // R3 write
        '{1'b1, 1'b0, 2'd0, A_CNT, 64'h0},                   // R3 next cycle V+1
        '{1'b1, 1'b0, 2'd0, A_ADJ, 64'h0},                   // R4 adjust moved
        '{1'b0, 1'b0, 2'd0, A_CNT, 64'h0},                   // idle gap
        '{1'b1, 1'b0, 2'd0, A_CNT, 64'h0},                   // R3 V+k
        '{1'b1, 1'b1, 2'd1, A_ADJ, 64'h0000_0000_0000_0500}, // R5 write
        '{1'b1, 1'b0, 2'd1, A_ADJ, 64'h0},                   // R6 readback
        '{1'b1, 1'b0, 2'd1, A_CNT, 64'h0},                   // R5 shift
        '{1'b1, 1'b1, 2'd1, A_ADJ, 64'h0000_0000_0000_0100}, // R5/R9 negative delta
        '{1'b1, 1'b0, 2'd1, A_CNT, 64'h0},                   // R5 shift back
        '{1'b1, 1'b0, 2'd0, A_CNT, 64'h0},                   // R7 cpu0 untouched
        '{1'b1, 1'b1, 2'd2, A_CNT, 64'h0},                   // R9 backward write
        '{1'b1, 1'b0, 2'd2, A_ADJ, 64'h0},                   // R4/R9 wrapped adjust
        '{1'b1, 1'b0, 2'd0, 12'h03C, 64'h0},                 // R8 bad read
        '{1'b1, 1'b1, 2'd2, 12'h011, 64'hDEAD_BEEF},         // R8 bad write
        '{1'b1, 1'b0, 2'd2, A_ADJ, 64'h0}                    // R8 write ignored
    };

    localparam string VTAG [NV] = '{
        "R3", "R3", "R4", "idle", "R3", "R5", "R6", "R5",
        "R9", "R5", "R7", "R9", "R4", "R8", "R8", "R8"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  cpu = '0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        err;

    logic [63:0] mdl_base;
    logic [63:0] m_off [4];
    logic [63:0] m_adj [4];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) mdl_base <= '0;
        else        mdl_base <= mdl_base + 64'd1;
    end

    tsc_adjust_unit i_tsc_adjust_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .wr       (wr),
        .cpu      (cpu),
        .addr     (addr),
        .wdata    (wdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .err      (err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_off[i] = '0;
            m_adj[i] = '0;
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic access(input vec_t v, input string tag);
        logic ok;
        logic [63:0] exp_data;
        logic [63:0] noff;
        ok = (v.addr == A_CNT) || (v.addr == A_ADJ);
        exp_data = '0;
        req   = v.req;
        wr    = v.wr;
        cpu   = v.cpu;
        addr  = v.addr;
        wdata = v.data;
        if (v.req && ok) begin
            if (!v.wr) begin
                exp_data = (v.addr == A_CNT) ? mdl_base + m_off[v.cpu] : m_adj[v.cpu];
            end else if (v.addr == A_CNT) begin
                noff = v.data - mdl_base;
                m_adj[v.cpu] = m_adj[v.cpu] + (noff - m_off[v.cpu]);
                m_off[v.cpu] = noff;
            end else begin
                m_off[v.cpu] = m_off[v.cpu] + (v.data - m_adj[v.cpu]);
                m_adj[v.cpu] = v.data;
            end
        end
        @(negedge clk);
        req = 1'b0;
        wr  = 1'b0;
        if (v.req) begin
            chk(tag, "err", 64'(err), 64'(!ok));
            chk(tag, "rd_valid", 64'(rd_valid), 64'(ok && !v.wr));
            if (!v.wr) chk(tag, "rd_data", rd_data, exp_data);
        end
    endtask

    function automatic vec_t mk(input logic w, input logic [1:0] c,
                                input logic [11:0] a, input logic [63:0] d);
        vec_t v;
        v.req = 1'b1; v.wr = w; v.cpu = c; v.addr = a; v.data = d;
        return v;
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state seen at the outputs
        chk("R1", "rd_valid at reset", 64'(rd_valid), 64'd0);
        chk("R1", "err at reset", 64'(err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) access(mk(1'b0, 2'(c), A_ADJ, '0), "R1");
        access(mk(1'b0, 2'd3, A_CNT, '0), "R1");

        // Vector table
        for (int i = 0; i < NV; i++) access(VEC[i], VTAG[i]);

        // R9: time-stamp wrap right after a write of all ones
        access(mk(1'b1, 2'd3, A_CNT, 64'hFFFF_FFFF_FFFF_FFFF), "R9");
        access(mk(1'b0, 2'd3, A_CNT, '0), "R9");
        access(mk(1'b0, 2'd3, A_ADJ, '0), "R4");
        // R5/R9: adjust written below zero
        access(mk(1'b1, 2'd3, A_ADJ, 64'hFFFF_FFFF_FFFF_FF00), "R5");
        access(mk(1'b0, 2'd3, A_ADJ, '0), "R6");
        access(mk(1'b0, 2'd3, A_CNT, '0), "R5");
        // R8: a bad write back-to-back, then the bad cycle's neighbours
        access(mk(1'b1, 2'd3, 12'h000, 64'h1234), "R8");
        access(mk(1'b0, 2'd3, A_CNT, '0), "R8");
        // R10: write reply leaves rd_data at zero
        access(mk(1'b1, 2'd0, A_ADJ, 64'h77), "R10");
        chk("R10", "rd_data after write", rd_data, 64'd0);

        // R1: reset during operation clears adjust state
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(mk(1'b0, 2'd0, A_ADJ, '0), "R1");
        access(mk(1'b0, 2'd1, A_CNT, '0), "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule